// File: doc/BRIEF.md
# Three-wire codec control bus master

This block drives a three-wire serial control bus of the kind used to set up audio codecs: one clock line, one bidirectional data line, and a mode line that tells the slave whether the byte on the wire is an address or payload. A local agent hands over a complete transaction in one cycle. The transaction carries a direction flag, an address byte, a data-byte count and up to `NDATA` payload bytes. The block then runs the whole burst on the bus without further help.

Every transaction starts with the address byte and continues with one or more data bytes. All bit and phase timing is set by module parameters counted in system clocks. On a read, the master stops driving the data line during the payload bytes and samples what the slave returns. When the burst ends, the lines go back to idle, a one-cycle completion strobe is raised, and any read bytes appear on a parallel output.

Top module: `tw_ctl_master`

## Requirements
- R1: A request is accepted on a rising clock edge where `req_valid` is high and the block is idle. The burst that follows is the address byte, sent exactly as given (device number in bits 7:2, register class in bits 1:0), then `req_nbytes`+1 data bytes. Data byte k is taken from `req_wdata[8k+7:8k]`.
- R2: Each byte goes out least significant bit first, 8 bits per byte. While the master drives the data line, `bus_dat_o` carries the current bit throughout that bit's low and high time, and is 1 during setup, hold and halt.
- R3: Each bit is one stretch of `bus_clk` low for `T_LOW` cycles, followed by `bus_clk` high for `T_HIGH` cycles.
- R4: Each byte is preceded by `T_SETUP` cycles with the clock high and followed by `T_HOLD` cycles with the clock high. The second and every later data byte is also preceded by a halt: the clock is low for `T_HALT` cycles, and then the setup time follows.
- R5: `bus_mode` is 0 for the whole address byte. It is 1 for every cycle of every data byte, including halt, setup and hold.
- R6: On a read, `bus_dat_oe` is 0 during all data bytes. `bus_dat_i` is sampled on the edge that ends the last low cycle of each bit. The bits are assembled LSB first into `rd_data[8k+7:8k]` for data byte k, and `rd_data` is cleared to 0 when a read is accepted.
- R7: When idle, `bus_clk`, `bus_mode`, `bus_dat_o`, `bus_dat_oe` and `bus_ctl_oe` are all 0. `bus_ctl_oe` is 1 in every cycle of a transaction. On a write, `bus_dat_oe` is 1 throughout the transaction.
- R8: `busy` is 1 from the cycle after acceptance through the last hold cycle. A request presented while busy is ignored and changes neither the bus nor the results.
- R9: `done` is a one-cycle pulse in the cycle after the last hold cycle, with `busy` already 0. A new request may be accepted in that same cycle. A write leaves `rd_data` unchanged.
- R10: While reset is asserted, and right after it, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_rd | input | 1 | 1 = read payload from slave, 0 = write |
| req_addr | input | 8 | Address byte (device in 7:2, class in 1:0) |
| req_nbytes | input | NW | Number of data bytes minus one |
| req_wdata | input | 8*NDATA | Write payload, byte k in bits 8k+7:8k |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | 8*NDATA | Read payload, byte k in bits 8k+7:8k |
| bus_clk | output | 1 | Bus clock line |
| bus_mode | output | 1 | Bus mode line, 0 address / 1 data |
| bus_ctl_oe | output | 1 | Drive enable for clock and mode lines |
| bus_dat_o | output | 1 | Data line output value |
| bus_dat_oe | output | 1 | Data line drive enable |
| bus_dat_i | input | 1 | Data line input value |

## Verification
The bound checker watches, on every cycle, the relations between the handshake and the pins. It checks that the lines are quiet whenever the block is idle and that the completion strobe is a lone pulse that closes each busy period. It checks that the mode line never drops inside a burst, and that the data driver is off whenever a read is in its payload. The exact cycle counts of each low, high, setup, hold and halt stretch, the LSB-first bit order, the byte assembly of read data, and the rejection of requests made while busy can only be shown by the bench. Its reference model predicts every pin on every cycle, and it also plays the slave on reads.

// File: rtl/tw_pkg.sv
package tw_pkg;

  // Bus phase of the master sequencer.
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_LOW   = 3'd2,
    PH_HIGH  = 3'd3,
    PH_HOLD  = 3'd4,
    PH_HALT  = 3'd5
  } phase_e;

  function automatic int unsigned tw_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tw_phase_timer.sv
module tw_phase_timer #(
  parameter int unsigned TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expire
);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = (cnt_q == '0);

endmodule

// File: rtl/tw_byte_path.sv
module tw_byte_path #(
  parameter int unsigned NDATA = 2,
  parameter int unsigned BW    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic               cap_rd,
  input  logic [7:0]         addr,
  input  logic [8*NDATA-1:0] wdata,
  input  logic [BW-1:0]      byte_idx,
  input  logic [2:0]         bit_idx,
  input  logic               sample,
  input  logic               dat_i,
  output logic               tx_bit,
  output logic [8*NDATA-1:0] rdata
);

  logic [7:0]         addr_q, addr_d;
  logic [8*NDATA-1:0] wdata_q, wdata_d;
  logic [7:0]         tx_arr [0:NDATA];

  // Request latch, enabled only at acceptance.
  always_comb begin
    addr_d  = addr_q;
    wdata_d = wdata_q;
    if (capture) begin
      addr_d  = addr;
      wdata_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  assign tx_arr[0] = addr_q;

  for (genvar k = 0; k < NDATA; k++) begin : g_byte
    logic [7:0] rx_q, rx_d;

    assign tx_arr[k+1] = wdata_q[8*k +: 8];

    always_comb begin
      rx_d = rx_q;
      if (capture && cap_rd)
        rx_d = '0;
      else if (sample && (byte_idx == BW'(k+1)))
        rx_d[bit_idx] = dat_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_q <= '0;
      else        rx_q <= rx_d;
    end

    assign rdata[8*k +: 8] = rx_q;
  end

  assign tx_bit = tx_arr[byte_idx][bit_idx];

endmodule

// File: rtl/tw_ctl_master.sv
module tw_ctl_master #(
  parameter int unsigned NDATA   = 2,
  parameter int unsigned T_LOW   = 4,
  parameter int unsigned T_HIGH  = 4,
  parameter int unsigned T_SETUP = 2,
  parameter int unsigned T_HOLD  = 2,
  parameter int unsigned T_HALT  = 4,
  localparam int unsigned NW     = (NDATA > 1) ? $clog2(NDATA) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_rd,
  input  logic [7:0]         req_addr,
  input  logic [NW-1:0]      req_nbytes,
  input  logic [8*NDATA-1:0] req_wdata,
  output logic               busy,
  output logic               done,
  output logic [8*NDATA-1:0] rd_data,
  output logic               bus_clk,
  output logic               bus_mode,
  output logic               bus_ctl_oe,
  output logic               bus_dat_o,
  output logic               bus_dat_oe,
  input  logic               bus_dat_i
);
  import tw_pkg::*;

  localparam int unsigned TMAX = tw_max(tw_max(tw_max(T_LOW, T_HIGH), tw_max(T_SETUP, T_HOLD)), T_HALT);
  localparam int unsigned TW   = (TMAX > 1) ? $clog2(TMAX) : 1;
  localparam int unsigned BW   = $clog2(NDATA + 1);

  phase_e          state_q, state_d;
  logic [BW-1:0]   byte_q, byte_d;
  logic [BW-1:0]   last_q, last_d;
  logic [2:0]      bit_q, bit_d;
  logic            rd_q, rd_d;
  logic            done_q, done_d;

  logic            accept;
  logic            expire;
  logic            tmr_load;
  logic [TW-1:0]   tmr_val;
  logic            sample;
  logic            tx_bit;

  assign accept = req_valid && (state_q == PH_IDLE);

  // Next-state logic of the phase sequencer.
  always_comb begin
    state_d = state_q;
    byte_d  = byte_q;
    last_d  = last_q;
    bit_d   = bit_q;
    rd_d    = rd_q;
    done_d  = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (accept) begin
          state_d = PH_SETUP;
          byte_d  = '0;
          bit_d   = '0;
          last_d  = BW'(req_nbytes) + BW'(1);
          rd_d    = req_rd;
        end
      end
      PH_SETUP: begin
        if (expire) begin
          state_d = PH_LOW;
          bit_d   = '0;
        end
      end
      PH_LOW: begin
        if (expire) state_d = PH_HIGH;
      end
      PH_HIGH: begin
        if (expire) begin
          if (bit_q == 3'd7) begin
            state_d = PH_HOLD;
          end else begin
            state_d = PH_LOW;
            bit_d   = bit_q + 3'd1;
          end
        end
      end
      PH_HOLD: begin
        if (expire) begin
          if (byte_q == last_q) begin
            state_d = PH_IDLE;
            done_d  = 1'b1;
          end else begin
            byte_d  = byte_q + BW'(1);
            state_d = (byte_q >= BW'(1)) ? PH_HALT : PH_SETUP;
          end
        end
      end
      PH_HALT: begin
        if (expire) state_d = PH_SETUP;
      end
      default: state_d = PH_IDLE;
    endcase
  end

  // Every phase change reloads the shared timer with the new phase length.
  always_comb begin
    tmr_load = (state_d != state_q);
    unique case (state_d)
      PH_SETUP: tmr_val = TW'(T_SETUP - 1);
      PH_LOW:   tmr_val = TW'(T_LOW - 1);
      PH_HIGH:  tmr_val = TW'(T_HIGH - 1);
      PH_HOLD:  tmr_val = TW'(T_HOLD - 1);
      PH_HALT:  tmr_val = TW'(T_HALT - 1);
      default:  tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      byte_q  <= '0;
      last_q  <= '0;
      bit_q   <= '0;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      byte_q  <= byte_d;
      last_q  <= last_d;
      bit_q   <= bit_d;
      rd_q    <= rd_d;
      done_q  <= done_d;
    end
  end

  tw_phase_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (expire)
  );

  // Sample in the final low cycle of a payload bit of a read.
  assign sample = (state_q == PH_LOW) && expire && rd_q && (byte_q != '0);

  tw_byte_path #(.NDATA(NDATA), .BW(BW)) u_bytes (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (accept),
    .cap_rd   (req_rd),
    .addr     (req_addr),
    .wdata    (req_wdata),
    .byte_idx (byte_q),
    .bit_idx  (bit_q),
    .sample   (sample),
    .dat_i    (bus_dat_i),
    .tx_bit   (tx_bit),
    .rdata    (rd_data)
  );

  // Pin decode.
  logic in_txn, bit_phase;
  assign in_txn     = (state_q != PH_IDLE);
  assign bit_phase  = (state_q == PH_LOW) || (state_q == PH_HIGH);
  assign busy       = in_txn;
  assign done       = done_q;
  assign bus_ctl_oe = in_txn;
  assign bus_clk    = (state_q == PH_SETUP) || (state_q == PH_HIGH) || (state_q == PH_HOLD);
  assign bus_mode   = in_txn && (byte_q != '0);
  assign bus_dat_oe = in_txn && !(rd_q && (byte_q != '0));
  assign bus_dat_o  = bus_dat_oe && (bit_phase ? tx_bit : 1'b1);

endmodule

// File: rtl/tw_ctl_master_chk.sv
module tw_ctl_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic bus_clk,
  input logic bus_mode,
  input logic bus_ctl_oe,
  input logic bus_dat_o,
  input logic bus_dat_oe,
  input logic txn_rd
);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_clk && !bus_mode && !bus_ctl_oe && !bus_dat_oe && !bus_dat_o));

  assert_ctl_driven_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bus_ctl_oe);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_busy_end_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_read_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_mode && txn_rd) |-> !bus_dat_oe);

  assert_mode_no_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !$fell(bus_mode));

  assert_addr_driven_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_dat_oe) |-> bus_mode);

endmodule

bind tw_ctl_master tw_ctl_master_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .bus_clk    (bus_clk),
  .bus_mode   (bus_mode),
  .bus_ctl_oe (bus_ctl_oe),
  .bus_dat_o  (bus_dat_o),
  .bus_dat_oe (bus_dat_oe),
  .txn_rd     (rd_q)
);

// File: tb/tw_ctl_master_bench.sv
module tw_ctl_master_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ND  = 2;
  localparam int TL  = 2;
  localparam int TH  = 3;
  localparam int TS  = 2;
  localparam int THO = 1;
  localparam int THA = 3;
  localparam int WATCHDOG = 200000;

  typedef struct packed {
    logic          clk;
    logic          mode;
    logic          ctl;
    logic          dat;
    logic          oe;
    logic          busy;
    logic          done;
    logic          sbit;
    logic [8*ND-1:0] rd;
  } exp_t;

  logic            clk;
  logic            rst_n;
  logic            req_valid;
  logic            req_rd;
  logic [7:0]      req_addr;
  logic [0:0]      req_nbytes;
  logic [8*ND-1:0] req_wdata;
  logic            busy, done;
  logic [8*ND-1:0] rd_data;
  logic            bus_clk, bus_mode, bus_ctl_oe, bus_dat_o, bus_dat_oe, bus_dat_i;

  tw_ctl_master #(
    .NDATA(ND), .T_LOW(TL), .T_HIGH(TH), .T_SETUP(TS), .T_HOLD(THO), .T_HALT(THA)
  ) u_tw_ctl_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rd(req_rd),
    .req_addr(req_addr), .req_nbytes(req_nbytes), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data),
    .bus_clk(bus_clk), .bus_mode(bus_mode), .bus_ctl_oe(bus_ctl_oe),
    .bus_dat_o(bus_dat_o), .bus_dat_oe(bus_dat_oe), .bus_dat_i(bus_dat_i)
  );

  exp_t            exp_q[$];
  logic [8*ND-1:0] rd_model;
  logic            cur_busy;
  bit              in_reset;
  bit              finished;
  int              n_checks;
  int              n_fails;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, expv, $time);
    end
  endtask

  task automatic push(input logic c, input logic m, input logic d, input logic oe,
                      input logic sb, input int n);
    exp_t e;
    e = '0;
    e.clk = c; e.mode = m; e.ctl = 1'b1; e.dat = d; e.oe = oe;
    e.busy = 1'b1; e.sbit = sb;
    for (int i = 0; i < n; i++) exp_q.push_back(e);
  endtask

  // Behavioural prediction of every bus cycle of one transaction.
  task automatic build(input logic rd, input logic [7:0] addr, input int nb,
                       input logic [8*ND-1:0] wdata, input logic [8*ND-1:0] sdata);
    exp_t e;
    for (int b = 0; b <= nb + 1; b++) begin
      logic [7:0] byt;
      logic [7:0] sb;
      logic       m, oe;
      byt = (b == 0) ? addr : wdata[8*(b-1) +: 8];
      sb  = (b == 0) ? 8'h00 : sdata[8*(b-1) +: 8];
      m   = (b != 0);
      oe  = !(rd && b != 0);
      if (b >= 2) push(1'b0, m, oe, oe, 1'b0, THA);
      push(1'b1, m, oe, oe, 1'b0, TS);
      for (int i = 0; i < 8; i++) begin
        push(1'b0, m, oe & byt[i], oe, rd & sb[i], TL);
        push(1'b1, m, oe & byt[i], oe, rd & sb[i], TH);
      end
      push(1'b1, m, oe, oe, 1'b0, THO);
    end
    if (rd) begin
      rd_model = '0;
      for (int b = 0; b <= nb; b++) rd_model[8*b +: 8] = sdata[8*b +: 8];
    end
    e = '0;
    e.done = 1'b1;
    e.rd = rd_model;
    exp_q.push_back(e);
  endtask

  task automatic tick();
    exp_t e;
    string tg;
    @(negedge clk);
    if (exp_q.size() > 0) e = exp_q.pop_front();
    else begin
      e = '0;
      e.rd = rd_model;
    end
    tg = in_reset ? "R10" : "";
    check(bus_clk === e.clk,     {tg, " R3 R4"}, "bus_clk", 32'(bus_clk), 32'(e.clk));
    check(bus_mode === e.mode,   {tg, " R5"},    "bus_mode", 32'(bus_mode), 32'(e.mode));
    check(bus_ctl_oe === e.ctl,  {tg, " R7"},    "bus_ctl_oe", 32'(bus_ctl_oe), 32'(e.ctl));
    check(bus_dat_o === e.dat,   {tg, " R2 R1"}, "bus_dat_o", 32'(bus_dat_o), 32'(e.dat));
    check(bus_dat_oe === e.oe,   {tg, " R6 R7"}, "bus_dat_oe", 32'(bus_dat_oe), 32'(e.oe));
    check(busy === e.busy,       {tg, " R1 R8"}, "busy", 32'(busy), 32'(e.busy));
    check(done === e.done,       {tg, " R9"},    "done", 32'(done), 32'(e.done));
    if (!e.busy)
      check(rd_data === e.rd,    {tg, " R6 R9"}, "rd_data", 32'(rd_data), 32'(e.rd));
    cur_busy  = e.busy;
    bus_dat_i = e.sbit;
  endtask

  // Present a request for one cycle; the model accepts it only when idle.
  task automatic request(input logic rd, input logic [7:0] addr, input int nb,
                         input logic [8*ND-1:0] wdata, input logic [8*ND-1:0] sdata);
    req_valid  = 1'b1;
    req_rd     = rd;
    req_addr   = addr;
    req_nbytes = 1'(nb);
    req_wdata  = wdata;
    if (!cur_busy) build(rd, addr, nb, wdata, sdata);
    tick();
    req_valid  = 1'b0;
    req_wdata  = '0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) tick();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    n_checks = 0; n_fails = 0; finished = 1'b0;
    rd_model = '0; cur_busy = 1'b0;
    rst_n = 1'b0; in_reset = 1'b1;
    req_valid = 1'b0; req_rd = 1'b0; req_addr = '0; req_nbytes = '0; req_wdata = '0;
    bus_dat_i = 1'b0;

    // R10: outputs quiet in and right after reset
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (2) tick();
    in_reset = 1'b0;

    // R1 R2 R3 R4 R5: write, single data byte
    request(1'b0, 8'h16, 0, 16'h00C5, '0);
    drain();
    repeat (2) tick();

    // R4 halt before second data byte, R2 bit order: write two bytes
    request(1'b0, 8'h15, 1, 16'h81A3, '0);
    drain();
    tick();

    // R6: read two bytes, slave returns 0x3C then 0xA5
    request(1'b1, 8'h17, 1, 16'hFFFF, 16'hA53C);
    drain();
    tick();

    // R6: read one byte clears the upper byte
    request(1'b1, 8'h14, 0, '0, 16'h5A96);
    drain();

    // R9: request accepted in the done cycle; write keeps rd_data
    request(1'b0, 8'hFC, 1, 16'h0F70, '0);
    repeat (20) tick();
    // R8: request while busy is ignored
    request(1'b1, 8'h03, 1, 16'h1234, 16'hFFFF);
    repeat (5) tick();
    request(1'b0, 8'h00, 0, 16'h00FF, '0);
    drain();
    repeat (3) tick();

    // R6 R9: read right after a write, all-ones and all-zeros bits
    request(1'b1, 8'h2A, 1, '0, 16'h00FF);
    drain();
    repeat (2) tick();

    summary();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule